// File: doc/BRIEF.md
# Tiered Parity Encoder and Chip-Erasure Rebuilder

This block protects one 512-bit cache line spread over nine memory chips. Chips 0 to 7 each carry a 57-bit segment and chip 8 carries a 56-bit segment. The encode side is purely combinational. From the line it forms a 57-bit column parity, a 7-bit second-tier parity over the stored parity fields, and a 9-bit detection code over both. The result is packed as one record byte per chip plus one spare bit, and the spare bit travels in chip 8's data word.

The rebuild side is used after the per-chip checksum (outside this block) has named one chip as dead. The caller presents the damaged line, the nine record bytes, the spare bit and the index of the dead chip through a valid/ready handshake. The block first recovers the dead chip's parity field from the surviving fields. It then checks the repaired parity against the detection code. If the check passes, it rebuilds the dead segment. A detection mismatch means a second fault, so the block raises an error and leaves the line uncorrected.

Top module: `tier_par_rebuild`

## Requirements
- R1: Segment c (c = 0..7) is line bits [57c+56:57c], and segment 8 is bits [511:456] with a 0 added as its bit 56. The column parity P is the XOR of all nine segments. Record byte c (c = 0..7) holds P[7c+6:7c] in bits [6:0]. The spare output carries P[56].
- R2: Bits [6:0] of record byte 8 hold the XOR of the bits [6:0] of record bytes 0 to 7.
- R3: The 63 covered bits are bit k (k = 0..6) of bits [6:0] of record byte c (c = 0..8). Detection bit i is the XOR of every covered bit with (c + 2k) mod 9 == i. Detection bit i is stored in bit 7 of record byte i.
- R4: With a dead chip index 0 to 7 and no other fault, the output line equals the original line, whatever the dead chip's segment and record byte contain.
- R5: With dead chip index 8 and no other fault, the output line equals the original line, whatever chip 8's segment, record byte and spare bit contain.
- R6: With a dead chip index 0 to 8 and a single flipped bit in another chip's record byte, the error output is 1 and the output line equals the input line unchanged.
- R7: A dead chip index of 9 to 15 passes the input line through unchanged, with the error output at 0.
- R8: A request is accepted on a clock edge where valid and ready are both 1. Ready is 0 in the following cycle. The result appears with output valid high for exactly one cycle, after the second edge following acceptance.
- R9: After reset, ready is 1 and output valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_line_i | input | 512 | Line to encode |
| enc_rec_o | output | 72 | Record, byte c belongs to chip c |
| enc_spare_o | output | 1 | Column parity bit 56 (spare bit in chip 8) |
| rb_valid_i | input | 1 | Rebuild request valid |
| rb_ready_o | output | 1 | Rebuild request can be accepted |
| rb_line_i | input | 512 | Line as read, possibly damaged |
| rb_rec_i | input | 72 | Record as read |
| rb_spare_i | input | 1 | Spare bit as read |
| rb_fail_i | input | 4 | Index of the dead chip; 9..15 means none |
| rb_valid_o | output | 1 | Result valid, one-cycle pulse |
| rb_line_o | output | 512 | Rebuilt or passed-through line |
| rb_err_o | output | 1 | Second fault detected, line not corrected |

## Verification
The encoder has no registers, so its record and spare bit are checked one time step after the line is applied, with no clock edge in between. A rebuild request is driven before edge N. Ready is sampled at 0 just after edge N. The line and error outputs are sampled together with output valid at the falling edge after edge N+1. Output valid is sampled low again one cycle later. Every sample is taken away from the rising edge, so no check depends on where a result register sits within a cycle.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
  localparam int NCHIP   = 9;
  localparam int FLD_W   = 7;
  localparam int SEG_W   = 57;
  localparam int LINE_W  = 512;
  localparam int LAST_W  = LINE_W - (NCHIP - 1) * SEG_W;
  localparam int BYTE_W  = FLD_W + 1;
  localparam int REC_W   = NCHIP * BYTE_W;
  localparam int COV_W   = NCHIP * FLD_W;
  localparam int IDX_W   = 4;
  localparam int DET_STEP = 2;

  function automatic logic [SEG_W-1:0] seg_of(input logic [LINE_W-1:0] line, input int c);
    if (c < NCHIP - 1) return line[c*SEG_W +: SEG_W];
    return {{(SEG_W-LAST_W){1'b0}}, line[LINE_W-1 -: LAST_W]};
  endfunction
endpackage

// File: rtl/tpr_det_gen.sv
module tpr_det_gen
  import tpr_pkg::*;
(
  input  logic [COV_W-1:0] cov_i,
  output logic [NCHIP-1:0] det_o
);
  // detection bit index = (chip + step*column) mod chip count
  always_comb begin
    det_o = '0;
    for (int c = 0; c < NCHIP; c++)
      for (int k = 0; k < FLD_W; k++)
        det_o[(c + DET_STEP*k) % NCHIP] ^= cov_i[c*FLD_W + k];
  end
endmodule

// File: rtl/tpr_enc.sv
module tpr_enc
  import tpr_pkg::*;
(
  input  logic [LINE_W-1:0] line_i,
  output logic [REC_W-1:0]  rec_o,
  output logic              spare_o
);
  logic [SEG_W-1:0] par;
  logic [FLD_W-1:0] t2;
  logic [COV_W-1:0] cov;
  logic [NCHIP-1:0] det;

  always_comb begin
    par = '0;
    for (int c = 0; c < NCHIP; c++) par ^= seg_of(line_i, c);
    t2 = '0;
    for (int c = 0; c < NCHIP - 1; c++) t2 ^= par[c*FLD_W +: FLD_W];
  end

  assign cov     = {t2, par[COV_W-FLD_W-1:0]};
  assign spare_o = par[SEG_W-1];

  tpr_det_gen u_det (.cov_i(cov), .det_o(det));

  for (genvar g = 0; g < NCHIP; g++) begin : g_pack
    assign rec_o[g*BYTE_W +: BYTE_W] = {det[g], cov[g*FLD_W +: FLD_W]};
  end
endmodule

// File: rtl/tpr_rebuild.sv
module tpr_rebuild
  import tpr_pkg::*;
(
  input  logic [LINE_W-1:0] line_i,
  input  logic [REC_W-1:0]  rec_i,
  input  logic              spare_i,
  input  logic [IDX_W-1:0]  fail_i,
  output logic [LINE_W-1:0] line_o,
  output logic              err_o
);
  logic [COV_W-1:0]  cov_rd, cov_fix;
  logic [NCHIP-1:0]  det_rd, det_calc, keep;
  logic [FLD_W-1:0]  lost_fld;
  logic [SEG_W-1:0]  par, lost_seg;
  logic [LINE_W-1:0] line_fix;
  logic              in_range;

  for (genvar g = 0; g < NCHIP; g++) begin : g_unpack
    assign cov_rd[g*FLD_W +: FLD_W] = rec_i[g*BYTE_W +: FLD_W];
    assign det_rd[g]                = rec_i[g*BYTE_W + FLD_W];
  end

  assign in_range = int'(fail_i) < NCHIP;

  // tier 2: dead chip's field = XOR of the eight surviving fields
  always_comb begin
    lost_fld = '0;
    for (int c = 0; c < NCHIP; c++)
      if (c != int'(fail_i)) lost_fld ^= cov_rd[c*FLD_W +: FLD_W];
    cov_fix = cov_rd;
    if (in_range) cov_fix[int'(fail_i)*FLD_W +: FLD_W] = lost_fld;
  end

  tpr_det_gen u_det (.cov_i(cov_fix), .det_o(det_calc));

  // detection bit held by the dead chip is not trusted
  assign keep  = ~(NCHIP'(1) << fail_i);
  assign err_o = in_range && |((det_calc ^ det_rd) & keep);

  assign par = {spare_i, cov_fix[COV_W-FLD_W-1:0]};

  always_comb begin
    lost_seg = par;
    for (int c = 0; c < NCHIP; c++)
      if (c != int'(fail_i)) lost_seg ^= seg_of(line_i, c);
    line_fix = line_i;
    if (int'(fail_i) < NCHIP - 1)
      line_fix[int'(fail_i)*SEG_W +: SEG_W] = lost_seg;
    else if (int'(fail_i) == NCHIP - 1)
      line_fix[LINE_W-1 -: LAST_W] = lost_seg[LAST_W-1:0];
  end

  assign line_o = (in_range && !err_o) ? line_fix : line_i;
endmodule

// File: rtl/tier_par_rebuild.sv
module tier_par_rebuild
  import tpr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] enc_line_i,
  output logic [REC_W-1:0]  enc_rec_o,
  output logic              enc_spare_o,
  input  logic              rb_valid_i,
  output logic              rb_ready_o,
  input  logic [LINE_W-1:0] rb_line_i,
  input  logic [REC_W-1:0]  rb_rec_i,
  input  logic              rb_spare_i,
  input  logic [IDX_W-1:0]  rb_fail_i,
  output logic              rb_valid_o,
  output logic [LINE_W-1:0] rb_line_o,
  output logic              rb_err_o
);
  logic              s1_v;
  logic [LINE_W-1:0] s1_line;
  logic [REC_W-1:0]  s1_rec;
  logic              s1_spare;
  logic [IDX_W-1:0]  s1_fail;
  logic [LINE_W-1:0] fix_line;
  logic              fix_err;
  logic              accept;

  tpr_enc u_enc (.line_i(enc_line_i), .rec_o(enc_rec_o), .spare_o(enc_spare_o));

  assign rb_ready_o = !s1_v;
  assign accept     = rb_valid_i && rb_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v       <= 1'b0;
      rb_valid_o <= 1'b0;
    end else begin
      s1_v       <= accept;
      rb_valid_o <= s1_v;
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept) begin
      s1_line  <= rb_line_i;
      s1_rec   <= rb_rec_i;
      s1_spare <= rb_spare_i;
      s1_fail  <= rb_fail_i;
    end
    if (s1_v) begin
      rb_line_o <= fix_line;
      rb_err_o  <= fix_err;
    end
  end

  tpr_rebuild u_rb (
    .line_i (s1_line),
    .rec_i  (s1_rec),
    .spare_i(s1_spare),
    .fail_i (s1_fail),
    .line_o (fix_line),
    .err_o  (fix_err)
  );
endmodule

// File: rtl/tier_par_rebuild_chk.sv
module tier_par_rebuild_chk
  import tpr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LINE_W-1:0] enc_line_i,
  input logic [REC_W-1:0]  enc_rec_o,
  input logic              enc_spare_o,
  input logic              rb_valid_i,
  input logic              rb_ready_o,
  input logic [LINE_W-1:0] rb_line_i,
  input logic [IDX_W-1:0]  rb_fail_i,
  input logic              rb_valid_o,
  input logic [LINE_W-1:0] rb_line_o,
  input logic              rb_err_o
);
  assert_spare_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_spare_o == (enc_line_i[56] ^ enc_line_i[113] ^ enc_line_i[170] ^ enc_line_i[227] ^
                    enc_line_i[284] ^ enc_line_i[341] ^ enc_line_i[398] ^ enc_line_i[455]));

  assert_tier2_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_rec_o[70:64] == (enc_rec_o[6:0] ^ enc_rec_o[14:8] ^ enc_rec_o[22:16] ^ enc_rec_o[30:24] ^
                         enc_rec_o[38:32] ^ enc_rec_o[46:40] ^ enc_rec_o[54:48] ^ enc_rec_o[62:56]));

  assert_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_valid_i && rb_ready_o) |=> !rb_ready_o);

  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_valid_i && rb_ready_o) |=> ##1 rb_valid_o);

  assert_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_valid_o |=> !rb_valid_o);

  assert_err_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_valid_o && rb_err_o) |-> rb_line_o == $past(rb_line_i, 2));

  assert_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_valid_o && $past(rb_valid_i && rb_ready_o, 2) && int'($past(rb_fail_i, 2)) >= NCHIP)
      |-> (!rb_err_o && rb_line_o == $past(rb_line_i, 2)));
endmodule

bind tier_par_rebuild tier_par_rebuild_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enc_line_i (enc_line_i),
  .enc_rec_o  (enc_rec_o),
  .enc_spare_o(enc_spare_o),
  .rb_valid_i (rb_valid_i),
  .rb_ready_o (rb_ready_o),
  .rb_line_i  (rb_line_i),
  .rb_fail_i  (rb_fail_i),
  .rb_valid_o (rb_valid_o),
  .rb_line_o  (rb_line_o),
  .rb_err_o   (rb_err_o)
);

// File: tb/tier_par_rebuild_bench.sv
module tier_par_rebuild_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [511:0] enc_line_i = '0;
  logic [71:0]  enc_rec_o;
  logic         enc_spare_o;
  logic         rb_valid_i = 1'b0;
  logic         rb_ready_o;
  logic [511:0] rb_line_i = '0;
  logic [71:0]  rb_rec_i = '0;
  logic         rb_spare_i = 1'b0;
  logic [3:0]   rb_fail_i = '0;
  logic         rb_valid_o;
  logic [511:0] rb_line_o;
  logic         rb_err_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  tier_par_rebuild u_tier_par_rebuild (.*);

  // {fail, corrupt chip (15 = none), corrupt bit, expected error}
  localparam logic [12:0] VEC [16] = '{
    {4'd0, 4'd15, 4'd0, 1'b0}, {4'd1, 4'd15, 4'd0, 1'b0}, {4'd2, 4'd15, 4'd0, 1'b0},
    {4'd3, 4'd15, 4'd0, 1'b0}, {4'd4, 4'd15, 4'd0, 1'b0}, {4'd5, 4'd15, 4'd0, 1'b0},
    {4'd6, 4'd15, 4'd0, 1'b0}, {4'd7, 4'd15, 4'd0, 1'b0}, {4'd8, 4'd15, 4'd0, 1'b0},
    {4'd9, 4'd15, 4'd0, 1'b0}, {4'd15, 4'd15, 4'd0, 1'b0},
    {4'd2, 4'd5, 4'd3, 1'b1}, {4'd0, 4'd8, 4'd7, 1'b1}, {4'd8, 4'd3, 4'd0, 1'b1},
    {4'd7, 4'd8, 4'd2, 1'b1}, {4'd4, 4'd1, 4'd7, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [56:0] seg(input logic [511:0] l, input int c);
    if (c < 8) return l[c*57 +: 57];
    return {1'b0, l[511:456]};
  endfunction

  // record and spare from the stated layout
  function automatic logic [72:0] ref_enc(input logic [511:0] l);
    logic [56:0] p = '0;
    logic [6:0]  f [9];
    logic [71:0] r = '0;
    for (int c = 0; c < 9; c++) p ^= seg(l, c);
    f[8] = '0;
    for (int c = 0; c < 8; c++) begin
      f[c] = p[c*7 +: 7];
      f[8] ^= f[c];
    end
    for (int c = 0; c < 9; c++) r[c*8 +: 7] = f[c];
    for (int c = 0; c < 9; c++)
      for (int k = 0; k < 7; k++)
        r[((c + 2*k) % 9)*8 + 7] ^= f[c][k];
    return {p[56], r};
  endfunction

  function automatic logic [511:0] rnd_line();
    logic [511:0] l;
    for (int w = 0; w < 16; w++) l[w*32 +: 32] = $urandom();
    return l;
  endfunction

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    if (!done) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [511:0] line, rd_line, exp_line;
    logic [72:0]  ref_v;
    logic [71:0]  rd_rec;
    logic         rd_spare;
    void'($urandom(32'h5eed));
    #5;
    check(rb_ready_o == 1'b1 && rb_valid_o == 1'b0, "R9 reset", {510'd0, rb_ready_o, rb_valid_o}, 512'd2);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    check(rb_ready_o == 1'b1 && rb_valid_o == 1'b0, "R9 after reset", {510'd0, rb_ready_o, rb_valid_o}, 512'd2);

    for (int v = 0; v < 16; v++) begin
      logic [3:0] f  = VEC[v][12:9];
      logic [3:0] cc = VEC[v][8:5];
      logic [3:0] cb = VEC[v][4:1];
      logic       ee = VEC[v][0];
      line = rnd_line();
      @(negedge clk_i);
      enc_line_i = line;
      #1;
      ref_v = ref_enc(line);
      check(enc_rec_o == ref_v[71:0] && enc_spare_o == ref_v[72], "R1 R2 R3 encode",
            {439'd0, enc_spare_o, enc_rec_o}, {439'd0, ref_v});
      rd_line = line; rd_rec = enc_rec_o; rd_spare = enc_spare_o;
      if (f < 8) rd_line[f*57 +: 57] = 57'({$urandom(), $urandom()});
      if (f == 8) begin
        rd_line[511:456] = 56'({$urandom(), $urandom()});
        rd_spare = ~rd_spare;
      end
      if (f < 9) rd_rec[f*8 +: 8] = ~rd_rec[f*8 +: 8];
      if (cc != 4'd15) rd_rec[cc*8 + cb] = ~rd_rec[cc*8 + cb];
      exp_line = (f < 9 && !ee) ? line : rd_line;
      @(negedge clk_i);
      rb_line_i = rd_line; rb_rec_i = rd_rec; rb_spare_i = rd_spare; rb_fail_i = f;
      rb_valid_i = 1'b1;
      @(posedge clk_i); #1;
      rb_valid_i = 1'b0;
      check(rb_ready_o == 1'b0, "R8 busy", {511'd0, rb_ready_o}, 512'd0);
      @(negedge clk_i);
      @(negedge clk_i);
      check(rb_valid_o == 1'b1, "R8 valid", {511'd0, rb_valid_o}, 512'd1);
      if (cc != 4'd15)
        check(rb_err_o == 1'b1 && rb_line_o == exp_line, "R6 second fault", rb_line_o, exp_line);
      else if (f == 8)
        check(rb_err_o == 1'b0 && rb_line_o == exp_line, "R5 chip 8 rebuild", rb_line_o, exp_line);
      else if (f < 8)
        check(rb_err_o == 1'b0 && rb_line_o == exp_line, "R4 chip rebuild", rb_line_o, exp_line);
      else
        check(rb_err_o == 1'b0 && rb_line_o == exp_line, "R7 pass-through", rb_line_o, exp_line);
      @(negedge clk_i);
      check(rb_valid_o == 1'b0 && rb_ready_o == 1'b1, "R8 pulse",
            {510'd0, rb_valid_o, rb_ready_o}, 512'd1);
    end

    // directed: valid held while busy gives a single result
    line = rnd_line();
    @(negedge clk_i);
    rb_line_i = line; rb_rec_i = '0; rb_fail_i = 4'd12; rb_valid_i = 1'b1;
    @(negedge clk_i);
    check(rb_ready_o == 1'b0, "R8 held busy", {511'd0, rb_ready_o}, 512'd0);
    rb_valid_i = 1'b0;
    @(negedge clk_i);
    check(rb_valid_o == 1'b1 && rb_line_o == line && !rb_err_o, "R7 R8 held", rb_line_o, line);
    @(negedge clk_i);
    check(rb_valid_o == 1'b0, "R8 held single", {511'd0, rb_valid_o}, 512'd0);

    // directed: reset mid-flight clears valid
    rb_valid_i = 1'b1;
    @(negedge clk_i);
    rb_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check(rb_valid_o == 1'b0 && rb_ready_o == 1'b1, "R9 mid reset",
          {510'd0, rb_valid_o, rb_ready_o}, 512'd1);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule